// File: doc/BRIEF.md
# Cell-to-PLCP Frame Assembler

This block wraps a stream of 53-octet ATM cells in a physical-layer convergence frame, so the stream can ride a plesiochronous line. Cells arrive one octet at a time on a valid/ready interface. Each cell becomes one row of the frame. A row starts with two fixed framing octets, then a row position code, then one path-overhead octet, and then the 53 cell octets. After the last row the block appends a trailer of stuff nibbles. In the 12-row build the trailer length tracks a stuffing request from the line side. In the 10-row build the trailer length is fixed.

The line side sets the pace. Each pulse on `nib_en` moves exactly one nibble out, and within each octet the high nibble goes first. If no cell is waiting when a row's cell portion begins, the block sends an idle cell in its place, so rows always follow each other without a gap. The block keeps an 8-bit even bit-interleaved parity over every frame. It writes that parity into an overhead octet of the next frame. A second overhead octet tells the far end which trailer length the current frame uses.

Top module: `plcp_assembler`

## Requirements
- R1: While `rst` is high, and after it falls until the first `nib_en` pulse, `out_nib` = 0, `out_sof` = 0 and `in_ready` = 0. This holds even if `nib_en` is high during reset.
- R2: Each row is sent as 0xF6, 0x28, the position code, the overhead octet and then 53 cell octets, with the high nibble of each octet first. Every `nib_en` pulse loads one nibble into `out_nib`, and the new value is visible in the cycle after the pulse. `out_sof` is 1 exactly while `out_nib` holds the first nibble of a frame's first row.
- R3: The position code counts rows remaining. It is 0x01 on the last row, and going toward the first row it runs 0x04, 0x08, 0x0D, 0x10, 0x15, 0x19, 0x1C, 0x20, 0x25, 0x29, 0x2C. A 12-row frame starts at 0x2C. A 10-row frame starts at 0x25.
- R4: Number the rows from the last row of the frame, with the last row as 0. The overhead octet of row 0 is the trailer-length code, the overhead octet of row 4 is the parity octet, and every other overhead octet is 0x00.
- R5: The trailer alternates 0xC and 0xD, and its first nibble is 0xC. In the 12-row build the trailer is 14 nibbles when `stuff_req` was high on the `nib_en` pulse that sent the previous frame's last trailer nibble, and 13 nibbles otherwise. The first frame after reset has 13 trailer nibbles. In the 10-row build the trailer is always 12 nibbles.
- R6: The trailer-length code is 0xFF for a 14-nibble trailer and 0x00 for a 13-nibble trailer. In the 10-row build the code is always 0x00.
- R7: The parity octet is the XOR of every position-code, overhead and cell octet sent in the previous frame. In the first frame after reset it is 0x00.
- R8: If `in_valid` is low on the pulse that sends the high nibble of a row's first cell octet, the whole row carries an idle cell. The idle cell is 0x00, 0x00, 0x00, 0x01, 0x52 followed by 48 octets of 0x6A. `in_ready` stays low for that row even if `in_valid` rises later in the row.
- R9: In a row that carries a real cell, `in_ready` is high exactly on the pulses that send the high nibble of a cell octet while `in_valid` is high, and the octet sent is `in_data`. If `in_valid` is low on such a pulse, the idle-cell octet for that position is sent (0x6A in the payload) and nothing is consumed.
- R10: While `nib_en` is low, `out_nib` and `out_sof` hold their values and `in_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A cell octet is offered |
| in_data | input | 8 | Offered cell octet |
| in_ready | output | 1 | Offered octet is taken at this edge |
| stuff_req | input | 1 | Line asks for the long trailer in the next frame |
| nib_en | input | 1 | Line takes one nibble at this edge |
| out_nib | output | 4 | Registered output nibble |
| out_sof | output | 1 | Output nibble is the first of a frame |

## Verification
The last trailer nibble of a frame has three jobs on the same `nib_en` pulse. It sends its own nibble, it hands the frame's parity over to the next frame's parity octet, and it samples `stuff_req` to pick the next frame's trailer length. The bench changes `stuff_req` just before that one pulse and nowhere else. It then checks the length of the next trailer, the code in that frame's last overhead octet, and the parity octet four rows earlier. These values are compared with a parity the bench keeps from the octets it expected to see. Idle rows and a starved octet in the middle of a cell are placed in the same frames, so the parity covers substituted octets as well as real ones.

// File: rtl/plcp_pkg.sv
package plcp_pkg;
  localparam int CELL_OCTS = 53;
  localparam int ROW_PFX   = 4;
  localparam int ROW_OCTS  = ROW_PFX + CELL_OCTS;
  localparam int OCT_W     = $clog2(ROW_OCTS);

  localparam logic [7:0] FRM_HI   = 8'hF6;
  localparam logic [7:0] FRM_LO   = 8'h28;
  localparam logic [7:0] IDL_HEC  = 8'h52;
  localparam logic [7:0] IDL_FILL = 8'h6A;
  localparam logic [3:0] STF_EVEN = 4'hC;
  localparam logic [3:0] STF_ODD  = 4'hD;

  // position code by rows remaining (0 = last row)
  function automatic logic [7:0] pos_code(input logic [3:0] rem);
    case (rem)
      4'd0:    pos_code = 8'h01;
      4'd1:    pos_code = 8'h04;
      4'd2:    pos_code = 8'h08;
      4'd3:    pos_code = 8'h0D;
      4'd4:    pos_code = 8'h10;
      4'd5:    pos_code = 8'h15;
      4'd6:    pos_code = 8'h19;
      4'd7:    pos_code = 8'h1C;
      4'd8:    pos_code = 8'h20;
      4'd9:    pos_code = 8'h25;
      4'd10:   pos_code = 8'h29;
      4'd11:   pos_code = 8'h2C;
      default: pos_code = 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] idle_octet(input logic [OCT_W-1:0] idx);
    if (idx < OCT_W'(3))       idle_octet = 8'h00;
    else if (idx == OCT_W'(3)) idle_octet = 8'h01;
    else if (idx == OCT_W'(4)) idle_octet = IDL_HEC;
    else                       idle_octet = IDL_FILL;
  endfunction
endpackage

// File: rtl/plcp_seq.sv
module plcp_seq
  import plcp_pkg::*;
#(
  parameter int NROWS     = 12,
  parameter int TRL_SHORT = 13,
  parameter int TRL_LONG  = 14,
  localparam int ROW_W    = $clog2(NROWS),
  localparam int TRL_W    = $clog2(TRL_LONG + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             stuff_req,
  output logic             in_trl,
  output logic [ROW_W-1:0] row_k,
  output logic [OCT_W-1:0] oct,
  output logic             hi,
  output logic [TRL_W-1:0] trl_idx,
  output logic             trl_long,
  output logic             wrap
);
  localparam bit CAN_STUFF = (TRL_LONG != TRL_SHORT);

  logic trl_end;
  assign trl_end = trl_idx == (trl_long ? TRL_W'(TRL_LONG - 1) : TRL_W'(TRL_SHORT - 1));
  assign wrap    = step && in_trl && trl_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_trl   <= 1'b0;
      row_k    <= ROW_W'(NROWS - 1);
      oct      <= '0;
      hi       <= 1'b1;
      trl_idx  <= '0;
      trl_long <= 1'b0;
    end else if (step) begin
      if (in_trl) begin
        if (trl_end) begin
          in_trl   <= 1'b0;
          row_k    <= ROW_W'(NROWS - 1);
          oct      <= '0;
          hi       <= 1'b1;
          trl_idx  <= '0;
          trl_long <= stuff_req && CAN_STUFF;
        end else begin
          trl_idx <= trl_idx + 1'b1;
        end
      end else if (hi) begin
        hi <= 1'b0;
      end else begin
        hi <= 1'b1;
        if (oct == OCT_W'(ROW_OCTS - 1)) begin
          oct <= '0;
          if (row_k == '0) in_trl <= 1'b1;
          else             row_k  <= row_k - 1'b1;
        end else begin
          oct <= oct + 1'b1;
        end
      end
    end
  end

  p_oct_range_r2: assert property (@(posedge clk) disable iff (rst)
    oct <= OCT_W'(ROW_OCTS - 1));
  p_trl_bound_r5: assert property (@(posedge clk) disable iff (rst)
    in_trl |-> trl_idx < (trl_long ? TRL_W'(TRL_LONG) : TRL_W'(TRL_SHORT)));
  p_seq_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(oct) && $stable(trl_idx) && $stable(hi));
endmodule

// File: rtl/plcp_octet_src.sv
module plcp_octet_src
  import plcp_pkg::*;
#(
  parameter int ROW_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             in_trl,
  input  logic             hi,
  input  logic [ROW_W-1:0] row_k,
  input  logic [OCT_W-1:0] oct,
  input  logic             trl_long,
  input  logic [7:0]       b1_val,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  output logic [7:0]       octet,
  output logic             in_ready
);
  logic             row_real, real_now, cell_pos, first_cell;
  logic [OCT_W-1:0] cidx;
  logic [7:0]       oh;

  assign first_cell = oct == OCT_W'(ROW_PFX);
  assign cell_pos   = oct >= OCT_W'(ROW_PFX);
  assign cidx       = oct - OCT_W'(ROW_PFX);
  assign real_now   = first_cell ? in_valid : row_real;
  assign in_ready   = !rst && step && hi && !in_trl && cell_pos && real_now && in_valid;

  always_ff @(posedge clk) begin
    if (rst) row_real <= 1'b0;
    else if (step && hi && !in_trl && first_cell) row_real <= in_valid;
  end

  always_comb begin
    if (row_k == '0)             oh = trl_long ? 8'hFF : 8'h00;
    else if (row_k == ROW_W'(4)) oh = b1_val;
    else                         oh = 8'h00;
  end

  always_comb begin
    case (oct)
      OCT_W'(0): octet = FRM_HI;
      OCT_W'(1): octet = FRM_LO;
      OCT_W'(2): octet = pos_code(4'(row_k));
      OCT_W'(3): octet = oh;
      default:   octet = (real_now && in_valid) ? in_data : idle_octet(cidx);
    endcase
  end

  p_ready_valid_r9: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> in_valid && step);
  p_idle_row_r8: assert property (@(posedge clk) disable iff (rst)
    (!row_real && oct > OCT_W'(ROW_PFX)) |-> !in_ready);
endmodule

// File: rtl/plcp_bip.sv
module plcp_bip
  import plcp_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             hi,
  input  logic             in_trl,
  input  logic [OCT_W-1:0] oct,
  input  logic [7:0]       octet,
  input  logic             wrap,
  output logic [7:0]       b1_val
);
  logic [7:0] acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc    <= '0;
      b1_val <= '0;
    end else if (wrap) begin
      acc    <= '0;
      b1_val <= acc;
    end else if (step && hi && !in_trl && oct >= OCT_W'(2)) begin
      acc <= acc ^ octet;
    end
  end

  p_b1_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(b1_val));
  p_acc_clear_r7: assert property (@(posedge clk) disable iff (rst)
    wrap |=> acc == 8'h00);
endmodule

// File: rtl/plcp_assembler.sv
module plcp_assembler
  import plcp_pkg::*;
#(
  parameter int NROWS = 12
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  input  logic       stuff_req,
  input  logic       nib_en,
  output logic [3:0] out_nib,
  output logic       out_sof
);
  localparam int TRL_SHORT = (NROWS == 12) ? 13 : 12;
  localparam int TRL_LONG  = (NROWS == 12) ? 14 : 12;
  localparam int ROW_W     = $clog2(NROWS);
  localparam int TRL_W     = $clog2(TRL_LONG + 1);

  logic             in_trl, hi, trl_long, wrap;
  logic [ROW_W-1:0] row_k;
  logic [OCT_W-1:0] oct;
  logic [TRL_W-1:0] trl_idx;
  logic [7:0]       octet, b1_val;
  logic [3:0]       lo_hold;

  plcp_seq #(.NROWS(NROWS), .TRL_SHORT(TRL_SHORT), .TRL_LONG(TRL_LONG)) u_seq (
    .clk(clk), .rst(rst), .step(nib_en), .stuff_req(stuff_req),
    .in_trl(in_trl), .row_k(row_k), .oct(oct), .hi(hi),
    .trl_idx(trl_idx), .trl_long(trl_long), .wrap(wrap)
  );

  plcp_octet_src #(.ROW_W(ROW_W)) u_src (
    .clk(clk), .rst(rst), .step(nib_en), .in_trl(in_trl), .hi(hi),
    .row_k(row_k), .oct(oct), .trl_long(trl_long), .b1_val(b1_val),
    .in_valid(in_valid), .in_data(in_data), .octet(octet), .in_ready(in_ready)
  );

  plcp_bip u_bip (
    .clk(clk), .rst(rst), .step(nib_en), .hi(hi), .in_trl(in_trl),
    .oct(oct), .octet(octet), .wrap(wrap), .b1_val(b1_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_nib <= '0;
      out_sof <= 1'b0;
      lo_hold <= '0;
    end else if (nib_en) begin
      out_sof <= !in_trl && hi && oct == '0 && row_k == ROW_W'(NROWS - 1);
      if (in_trl) begin
        out_nib <= trl_idx[0] ? STF_ODD : STF_EVEN;
      end else if (hi) begin
        out_nib <= octet[7:4];
        lo_hold <= octet[3:0];
      end else begin
        out_nib <= lo_hold;
      end
    end
  end

  p_trl_nib_r5: assert property (@(posedge clk) disable iff (rst)
    (nib_en && in_trl) |=> (out_nib == STF_EVEN || out_nib == STF_ODD));
  p_sof_a1_r2: assert property (@(posedge clk) disable iff (rst)
    out_sof |-> out_nib == FRM_HI[7:4]);
  p_out_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !nib_en |=> $stable(out_nib) && $stable(out_sof));
  p_ready_step_r10: assert property (@(posedge clk) disable iff (rst)
    !nib_en |-> !in_ready);
endmodule

// File: tb/plcp_assembler_bench.sv
`timescale 1ns/1ps
module plcp_assembler_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic stuff_req = 1'b0;
  logic nib_en_a = 1'b0, nib_en_b = 1'b0;
  logic rdy_a, rdy_b, sof_a, sof_b;
  logic [3:0] nib_a, nib_b;

  int n_chk = 0, n_fail = 0;
  logic [7:0] seq = 8'h10;
  logic long_a = 1'b0, long_b = 1'b0;
  logic [7:0] bip_prev [2];
  int gap_ctr = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  plcp_assembler #(.NROWS(12)) u_plcp_assembler (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_ready(rdy_a),
    .stuff_req(stuff_req), .nib_en(nib_en_a), .out_nib(nib_a), .out_sof(sof_a));

  plcp_assembler #(.NROWS(10)) u_plcp_assembler_10 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_ready(rdy_b),
    .stuff_req(stuff_req), .nib_en(nib_en_b), .out_nib(nib_b), .out_sof(sof_b));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_pos(input int rem);
    case (rem)
      0: return 8'h01;  1: return 8'h04;  2: return 8'h08;  3: return 8'h0D;
      4: return 8'h10;  5: return 8'h15;  6: return 8'h19;  7: return 8'h1C;
      8: return 8'h20;  9: return 8'h25; 10: return 8'h29; 11: return 8'h2C;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] exp_idle(input int i);
    if (i < 3) return 8'h00;
    if (i == 3) return 8'h01;
    if (i == 4) return 8'h52;
    return 8'h6A;
  endfunction

  // one nibble: pulse nib_en for one edge, check ready at the pulse and the nibble after it
  task automatic do_step(input int sel, input logic [3:0] exp_nib, input logic exp_rdy,
                         input bit chk_sof, input logic exp_sof, input string req, input bit gaps);
    logic rdy, took;
    logic [3:0] nb;
    logic sf;
    @(negedge clk);
    if (sel == 0) nib_en_a = 1'b1; else nib_en_b = 1'b1;
    #1;
    rdy = (sel == 0) ? rdy_a : rdy_b;
    chk(rdy === exp_rdy, {req, " in_ready"}, int'(rdy), int'(exp_rdy));
    took = rdy;
    @(negedge clk);
    nib_en_a = 1'b0; nib_en_b = 1'b0;
    if (took) seq = seq + 8'h01;
    nb = (sel == 0) ? nib_a : nib_b;
    sf = (sel == 0) ? sof_a : sof_b;
    chk(nb === exp_nib, {req, " nibble"}, int'(nb), int'(exp_nib));
    if (chk_sof) chk(sf === exp_sof, "R2 out_sof", int'(sf), int'(exp_sof));
    if (gaps) begin
      gap_ctr++;
      if (gap_ctr % 7 == 0) begin
        repeat (2) @(negedge clk);
        chk(((sel == 0) ? nib_a : nib_b) === nb, "R10 hold nibble",
            int'((sel == 0) ? nib_a : nib_b), int'(nb));
        chk(((sel == 0) ? rdy_a : rdy_b) === 1'b0, "R10 ready idle", 1, 0);
      end
    end
  endtask

  task automatic run_frame(input int sel, input int nr, input bit stuff_next,
                           input logic [11:0] idle_rows, input int starve_row, input bit gaps);
    logic [7:0] acc = 8'h00;
    logic [7:0] b;
    logic rdy;
    bit lng = (sel == 0) ? long_a : long_b;
    int trl = (nr == 12) ? (lng ? 14 : 13) : 12;
    string req;
    for (int r = 0; r < nr; r++) begin
      int k = nr - 1 - r;
      for (int o = 0; o < 57; o++) begin
        rdy = 1'b0;
        in_valid = 1'b1;
        in_data = seq;
        if (o == 0)      begin b = 8'hF6; req = "R2 A-octet"; end
        else if (o == 1) begin b = 8'h28; req = "R2 B-octet"; end
        else if (o == 2) begin b = exp_pos(k); req = "R3 position"; end
        else if (o == 3) begin
          if (k == 0)      begin b = lng ? 8'hFF : 8'h00; req = "R6 length code"; end
          else if (k == 4) begin b = bip_prev[sel]; req = "R7 parity"; end
          else             begin b = 8'h00; req = "R4 overhead"; end
        end else begin
          int ci = o - 4;
          if (idle_rows[r]) begin
            in_valid = (ci != 0);
            b = exp_idle(ci); req = "R8 idle cell";
          end else if (r == starve_row && ci == 20) begin
            in_valid = 1'b0;
            b = 8'h6A; req = "R9 starved octet";
          end else begin
            b = seq; rdy = 1'b1; req = "R9 cell octet";
          end
        end
        if (o >= 2) acc = acc ^ b;
        do_step(sel, b[7:4], rdy, (r == 0 && o == 0), 1'b1, req, gaps);
        do_step(sel, b[3:0], 1'b0, (r == 0 && o == 0), 1'b0, req, gaps);
      end
    end
    in_valid = 1'b1;
    for (int t = 0; t < trl; t++) begin
      if (t == trl - 1) stuff_req = stuff_next;
      do_step(sel, (t % 2 == 1) ? 4'hD : 4'hC, 1'b0, 1'b0, 1'b0, "R5 trailer", gaps);
    end
    // the next frame starts without a trailer nibble: first nibble must be the A-octet
    do_step(sel, 4'hF, 1'b0, 1'b1, 1'b1, "R5 trailer end", 1'b0);
    bip_prev[sel] = acc;
    if (sel == 0) long_a = (nr == 12) && stuff_next; else long_b = 1'b0;
  endtask

  // the frame check consumed the first nibble of the next frame; finish that octet
  task automatic finish_first_octet(input int sel);
    do_step(sel, 4'h6, 1'b0, 1'b1, 1'b0, "R2 A-octet low", 1'b0);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    nib_en_a = 1'b1; nib_en_b = 1'b1; in_valid = 1'b1;
    repeat (3) @(negedge clk);
    chk(rdy_a === 1'b0 && rdy_b === 1'b0, "R1 ready in reset", int'(rdy_a | rdy_b), 0);
    nib_en_a = 1'b0; nib_en_b = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(nib_a === 4'h0 && nib_b === 4'h0, "R1 nibble after reset", int'(nib_a), 0);
    chk(sof_a === 1'b0 && sof_b === 1'b0, "R1 sof after reset", int'(sof_a), 0);
    chk(rdy_a === 1'b0 && rdy_b === 1'b0, "R1 ready after reset", int'(rdy_a), 0);
  endtask

  // R2 R3 R4 R7 R9: every row real, request long trailer at the wrap
  task automatic t_plain_frame;
    run_frame(0, 12, 1'b1, 12'h000, -1, 1'b0);
  endtask

  // R5 R6 R7 R8 R9: long trailer, idle rows and a starved octet in one frame
  task automatic t_stuffed_idle;
    finish_first_octet(0);
    run_frame_tail(0, 12, 1'b0, 12'b0000_0100_0011, 3, 1'b0);
  endtask

  // R10: gaps between nibbles
  task automatic t_gaps;
    finish_first_octet(0);
    run_frame_tail(0, 12, 1'b0, 12'h000, -1, 1'b1);
  endtask

  // R3 R5 R6: ten-row build ignores the stuffing request
  task automatic t_ten_rows;
    stuff_req = 1'b1;
    run_frame(1, 10, 1'b1, 12'b0000_0000_0100, -1, 1'b0);
    finish_first_octet(1);
    run_frame_tail(1, 10, 1'b1, 12'h000, 5, 1'b0);
    stuff_req = 1'b0;
  endtask

  // like run_frame but the first octet of row 0 has already been sent
  task automatic run_frame_tail(input int sel, input int nr, input bit stuff_next,
                                input logic [11:0] idle_rows, input int starve_row, input bit gaps);
    logic [7:0] acc = 8'h00;
    logic [7:0] b;
    logic rdy;
    bit lng = (sel == 0) ? long_a : long_b;
    int trl = (nr == 12) ? (lng ? 14 : 13) : 12;
    string req;
    for (int r = 0; r < nr; r++) begin
      int k = nr - 1 - r;
      for (int o = (r == 0) ? 1 : 0; o < 57; o++) begin
        rdy = 1'b0;
        in_valid = 1'b1;
        in_data = seq;
        if (o == 0)      begin b = 8'hF6; req = "R2 A-octet"; end
        else if (o == 1) begin b = 8'h28; req = "R2 B-octet"; end
        else if (o == 2) begin b = exp_pos(k); req = "R3 position"; end
        else if (o == 3) begin
          if (k == 0)      begin b = lng ? 8'hFF : 8'h00; req = "R6 length code"; end
          else if (k == 4) begin b = bip_prev[sel]; req = "R7 parity"; end
          else             begin b = 8'h00; req = "R4 overhead"; end
        end else begin
          int ci = o - 4;
          if (idle_rows[r]) begin
            in_valid = (ci != 0);
            b = exp_idle(ci); req = "R8 idle cell";
          end else if (r == starve_row && ci == 20) begin
            in_valid = 1'b0;
            b = 8'h6A; req = "R9 starved octet";
          end else begin
            b = seq; rdy = 1'b1; req = "R9 cell octet";
          end
        end
        if (o >= 2) acc = acc ^ b;
        do_step(sel, b[7:4], rdy, 1'b0, 1'b0, req, gaps);
        do_step(sel, b[3:0], 1'b0, 1'b0, 1'b0, req, gaps);
      end
    end
    in_valid = 1'b1;
    for (int t = 0; t < trl; t++) begin
      if (t == trl - 1) stuff_req = stuff_next;
      do_step(sel, (t % 2 == 1) ? 4'hD : 4'hC, 1'b0, 1'b0, 1'b0, "R5 trailer", gaps);
    end
    do_step(sel, 4'hF, 1'b0, 1'b1, 1'b1, "R5 trailer end", 1'b0);
    bip_prev[sel] = acc;
    if (sel == 0) long_a = (nr == 12) && stuff_next; else long_b = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    bip_prev[0] = 8'h00;
    bip_prev[1] = 8'h00;
    t_reset();
    t_plain_frame();
    t_stuffed_idle();
    t_gaps();
    t_ten_rows();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule